// File: doc/BRIEF.md
# Hardware Loop Context Stack

This block keeps the nested zero-overhead-loop contexts of a small processor core. Each stored context bundles three values: the address where the loop body starts, the address of the instruction that closes the loop, and a 16-bit count of the passes still to run. The newest context is always visible on the outputs, together with empty and full flags. A surrounding loop controller compares program counters against those outputs and drives the strobes.

The controller pushes a context when a loop is set up. It presents the iteration total minus one as the count. Each time the closing instruction executes, it either decrements the top count in place, which keeps the depth and both addresses, or it pops the context once the count has already reached zero. The stack depth is a parameter and defaults to two. An asynchronous active-low reset and a synchronous clear input both empty the stack.

Top module: `loop_ctx_stack`

## Requirements
- R1: After the asynchronous reset (arst_n low) or a cycle with clr high, empty_o is 1 and full_o is 0. clr overrides every strobe in the same cycle.
- R2: A push on a stack that is not full, without pop, stores beg_i, end_i and cnt_i as the new top entry from the next cycle on and adds one to the depth. full_o rises once DEPTH entries are held.
- R3: A pop on a non-empty stack, without push, removes the top entry. The entry below it reappears unchanged on the top outputs from the next cycle.
- R4: A decrement alone, on a non-empty stack whose top count is above zero, lowers top_cnt_o by exactly one. The depth, top_beg_o and top_end_o stay the same.
- R5: A decrement on a top count of zero leaves it at zero and does not wrap.
- R6: A push while full, without pop, is ignored. The contents, the depth and the top outputs do not change.
- R7: A pop or a decrement while empty is ignored, and the stack stays empty.
- R8: Push and pop in the same cycle replace the top entry with the new values and keep the depth. On an empty stack the pair acts as a plain push.
- R9: Priority order is clr, then push, then pop, then decrement. A decrement that meets push or pop in the same cycle is dropped, even when the push itself is refused because the stack is full.
- R10: While the stack is empty, top_beg_o, top_end_o and top_cnt_o all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| push | input | 1 | Push a new loop context |
| pop | input | 1 | Remove the top loop context |
| dec | input | 1 | Decrement the top count in place |
| beg_i | input | ADDR_W | Loop body start address for a push |
| end_i | input | ADDR_W | Loop closing address for a push |
| cnt_i | input | 16 | Remaining passes (total minus one) for a push |
| top_beg_o | output | ADDR_W | Start address of the top context |
| top_end_o | output | ADDR_W | Closing address of the top context |
| top_cnt_o | output | 16 | Count of the top context |
| empty_o | output | 1 | No context held |
| full_o | output | 1 | DEPTH contexts held |

## Verification
Every strobe takes effect at the next rising edge. Its result shows on the top outputs and flags in that same cycle, one register stage after the strobe is sampled. The asynchronous reset is the exception: it empties the stack at once, with no clock edge. The bench drives strobes on the falling edge and advances its queue model at the following rising edge. It compares every output at the next falling edge, so each check lands exactly one cycle after its stimulus. The reset is checked a short delay after arst_n falls, with no edge in between.

// File: rtl/loop_ctx_pkg.sv
// Shared definitions for the loop context stack: count width and the
// resolved per-cycle operation. Assumes one operation per clock cycle.
package loop_ctx_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_SWAP  = 3'd4,
        OP_DEC   = 3'd5
    } stk_op_e;

endpackage

// File: rtl/loop_ctx_arb.sv
// Resolves the raw strobes into one operation per cycle.
// Order: clear, then push (swap when paired with pop), then pop, then
// decrement. Refused operations (push on full, pop/dec on empty) become
// idle. Assumes the flags describe the current, registered depth.
module loop_ctx_arb
    import loop_ctx_pkg::*;
(
    input  logic    clr,
    input  logic    push,
    input  logic    pop,
    input  logic    dec,
    input  logic    empty,
    input  logic    full,
    output stk_op_e op
);

    // Priority resolution of the strobes into a single operation
    always_comb begin
        op = OP_IDLE;
        if (clr) begin
            op = OP_CLEAR;
        end else if (push && pop) begin
            op = empty ? OP_PUSH : OP_SWAP;
        end else if (push) begin
            op = full ? OP_IDLE : OP_PUSH;
        end else if (pop) begin
            op = empty ? OP_IDLE : OP_POP;
        end else if (dec) begin
            op = empty ? OP_IDLE : OP_DEC;
        end
    end

endmodule

// File: rtl/loop_ctx_level.sv
// Holds the number of stored contexts and derives the flags and the
// index of the top slot. Assumes op was already checked against the
// flags, so the level never leaves 0..DEPTH.
module loop_ctx_level
    import loop_ctx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  stk_op_e          op,
    output logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] top_idx,
    output logic             empty,
    output logic             full
);

    logic [LVL_W-1:0] level_q;

    // Depth counter: up on push, down on pop, zero on clear or reset
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            level_q <= '0;
        end else begin
            case (op)
                OP_CLEAR: level_q <= '0;
                OP_PUSH:  level_q <= level_q + 1'b1;
                OP_POP:   level_q <= level_q - 1'b1;
                default:  level_q <= level_q;
            endcase
        end
    end

    // Flags and top slot index derived from the depth
    always_comb begin
        level   = level_q;
        empty   = (level_q == '0);
        full    = (level_q == LVL_W'(DEPTH));
        top_idx = IDX_W'(level_q - 1'b1);
    end

endmodule

// File: rtl/loop_ctx_slots.sv
// Storage of the loop contexts, one register group per slot. A push
// writes the slot just above the top, a swap overwrites the top, and a
// decrement lowers the top count with a floor at zero. Assumes the
// level and top index come from loop_ctx_level.
module loop_ctx_slots
    import loop_ctx_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              arst_n,
    input  stk_op_e           op,
    input  logic [LVL_W-1:0]  level,
    input  logic [IDX_W-1:0]  top_idx,
    input  logic [ADDR_W-1:0] beg_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] rd_beg,
    output logic [ADDR_W-1:0] rd_end,
    output logic [CNT_W-1:0]  rd_cnt
);

    logic [ADDR_W-1:0] beg_q [DEPTH];
    logic [ADDR_W-1:0] end_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic is_top;
        logic load;
        logic step;

        // Per-slot write and decrement enables
        always_comb begin
            is_top = (top_idx == IDX_W'(s));
            load   = ((op == OP_PUSH) && (level == LVL_W'(s))) ||
                     ((op == OP_SWAP) && is_top);
            step   = (op == OP_DEC) && is_top;
        end

        // Slot registers: load a new context or decrement the count
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                beg_q[s] <= '0;
                end_q[s] <= '0;
                cnt_q[s] <= '0;
            end else if (op == OP_CLEAR) begin
                beg_q[s] <= '0;
                end_q[s] <= '0;
                cnt_q[s] <= '0;
            end else if (load) begin
                beg_q[s] <= beg_i;
                end_q[s] <= end_i;
                cnt_q[s] <= cnt_i;
            end else if (step && (cnt_q[s] != '0)) begin
                cnt_q[s] <= cnt_q[s] - 1'b1;
            end
        end
    end

    // Read mux for the top slot; no slot matches an out-of-range index
    always_comb begin
        rd_beg = '0;
        rd_end = '0;
        rd_cnt = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (top_idx == IDX_W'(s)) begin
                rd_beg = beg_q[s];
                rd_end = end_q[s];
                rd_cnt = cnt_q[s];
            end
        end
    end

endmodule

// File: rtl/loop_ctx_stack.sv
// Top of the loop context stack. It connects the strobe arbiter, the
// depth counter and the slot storage, and forces the top outputs to zero
// while nothing is held. Assumes at most one logical operation per cycle,
// resolved by loop_ctx_arb.
module loop_ctx_stack
    import loop_ctx_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int ADDR_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic              dec,
    input  logic [ADDR_W-1:0] beg_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] top_beg_o,
    output logic [ADDR_W-1:0] top_end_o,
    output logic [CNT_W-1:0]  top_cnt_o,
    output logic              empty_o,
    output logic              full_o
);

    stk_op_e           op;
    logic [LVL_W-1:0]  level;
    logic [IDX_W-1:0]  top_idx;
    logic              empty;
    logic              full;
    logic [ADDR_W-1:0] rd_beg;
    logic [ADDR_W-1:0] rd_end;
    logic [CNT_W-1:0]  rd_cnt;

    loop_ctx_arb u_arb (
        .clr   (clr),
        .push  (push),
        .pop   (pop),
        .dec   (dec),
        .empty (empty),
        .full  (full),
        .op    (op)
    );

    loop_ctx_level #(.DEPTH(DEPTH)) u_level (
        .clk     (clk),
        .arst_n  (arst_n),
        .op      (op),
        .level   (level),
        .top_idx (top_idx),
        .empty   (empty),
        .full    (full)
    );

    loop_ctx_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_slots (
        .clk     (clk),
        .arst_n  (arst_n),
        .op      (op),
        .level   (level),
        .top_idx (top_idx),
        .beg_i   (beg_i),
        .end_i   (end_i),
        .cnt_i   (cnt_i),
        .rd_beg  (rd_beg),
        .rd_end  (rd_end),
        .rd_cnt  (rd_cnt)
    );

    // Output gating: zero fields while the stack holds nothing
    always_comb begin
        empty_o   = empty;
        full_o    = full;
        top_beg_o = empty ? '0 : rd_beg;
        top_end_o = empty ? '0 : rd_end;
        top_cnt_o = empty ? '0 : rd_cnt;
    end

endmodule

// File: rtl/loop_ctx_stack_chk.sv
// Property checker for loop_ctx_stack, bound to every instance. It sees
// only the ports and relates strobes to the outputs one cycle later.
module loop_ctx_stack_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              arst_n,
    input logic              clr,
    input logic              push,
    input logic              pop,
    input logic              dec,
    input logic [ADDR_W-1:0] beg_i,
    input logic [ADDR_W-1:0] end_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [ADDR_W-1:0] top_beg_o,
    input logic [ADDR_W-1:0] top_end_o,
    input logic [CNT_W-1:0]  top_cnt_o,
    input logic              empty_o,
    input logic              full_o
);

    // R1
    clear_empties_chk: assert property (@(posedge clk) disable iff (!arst_n)
        clr |=> (empty_o && !full_o));

    // R2
    push_lands_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && push && !pop && !full_o) |=>
            (!empty_o && top_beg_o == $past(beg_i) && top_end_o == $past(end_i)
             && top_cnt_o == $past(cnt_i)));

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && dec && !push && !pop && !empty_o && top_cnt_o != '0) |=>
            (top_cnt_o == $past(top_cnt_o) - 1'b1 && $stable(top_beg_o)
             && $stable(top_end_o) && $stable(empty_o) && $stable(full_o)));

    // R5
    dec_floor_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && dec && !push && !pop && !empty_o && top_cnt_o == '0) |=>
            (top_cnt_o == '0));

    // R6
    full_push_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && push && !pop && full_o) |=>
            (full_o && $stable(top_beg_o) && $stable(top_end_o) && $stable(top_cnt_o)));

    // R7
    empty_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && !push && empty_o) |=> empty_o);

    // R8
    swap_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && push && pop && !empty_o) |=>
            ($stable(empty_o) && $stable(full_o) && top_beg_o == $past(beg_i)
             && top_end_o == $past(end_i) && top_cnt_o == $past(cnt_i)));

    // R10
    empty_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        empty_o |-> (top_beg_o == '0 && top_end_o == '0 && top_cnt_o == '0 && !full_o));

endmodule

bind loop_ctx_stack loop_ctx_stack_chk #(.ADDR_W(ADDR_W), .CNT_W(loop_ctx_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .clr       (clr),
    .push      (push),
    .pop       (pop),
    .dec       (dec),
    .beg_i     (beg_i),
    .end_i     (end_i),
    .cnt_i     (cnt_i),
    .top_beg_o (top_beg_o),
    .top_end_o (top_end_o),
    .top_cnt_o (top_cnt_o),
    .empty_o   (empty_o),
    .full_o    (full_o)
);

// File: tb/sim_loop_ctx_stack.sv
// Bench for loop_ctx_stack: a queue-based reference model advanced at
// every rising edge, compared with the outputs at every falling edge.
module sim_loop_ctx_stack;

    localparam int DEPTH  = 2;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              arst_n = 1'b0;
    logic              clr = 1'b0;
    logic              push = 1'b0;
    logic              pop = 1'b0;
    logic              dec = 1'b0;
    logic [ADDR_W-1:0] beg_i = '0;
    logic [ADDR_W-1:0] end_i = '0;
    logic [CNT_W-1:0]  cnt_i = '0;
    logic [ADDR_W-1:0] top_beg_o;
    logic [ADDR_W-1:0] top_end_o;
    logic [CNT_W-1:0]  top_cnt_o;
    logic              empty_o;
    logic              full_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [ADDR_W-1:0] m_beg [$];
    logic [ADDR_W-1:0] m_end [$];
    logic [CNT_W-1:0]  m_cnt [$];

    always #5 clk = ~clk;

    loop_ctx_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
        .clk       (clk),
        .arst_n    (arst_n),
        .clr       (clr),
        .push      (push),
        .pop       (pop),
        .dec       (dec),
        .beg_i     (beg_i),
        .end_i     (end_i),
        .cnt_i     (cnt_i),
        .top_beg_o (top_beg_o),
        .top_end_o (top_end_o),
        .top_cnt_o (top_cnt_o),
        .empty_o   (empty_o),
        .full_o    (full_o)
    );

    // Empty the model, as a reset or clear does
    task automatic model_clear();
        m_beg.delete();
        m_end.delete();
        m_cnt.delete();
    endtask

    // Advance the model by one edge using the strobes currently driven
    task automatic model_step();
        int n;
        n = m_cnt.size();
        if (clr) begin
            model_clear();
        end else if (push && pop && n > 0) begin
            m_beg[n-1] = beg_i;
            m_end[n-1] = end_i;
            m_cnt[n-1] = cnt_i;
        end else if (push) begin
            if (n < DEPTH) begin
                m_beg.push_back(beg_i);
                m_end.push_back(end_i);
                m_cnt.push_back(cnt_i);
            end
        end else if (pop) begin
            if (n > 0) begin
                void'(m_beg.pop_back());
                void'(m_end.pop_back());
                void'(m_cnt.pop_back());
            end
        end else if (dec) begin
            if (n > 0 && m_cnt[n-1] != '0) begin
                m_cnt[n-1] = m_cnt[n-1] - 1'b1;
            end
        end
    endtask

    // Compare all outputs against the model
    task automatic compare(input string tag);
        logic [ADDR_W-1:0] eb;
        logic [ADDR_W-1:0] ee;
        logic [CNT_W-1:0]  ec;
        logic              xe;
        logic              xf;
        int n;
        n  = m_cnt.size();
        xe = (n == 0);
        xf = (n == DEPTH);
        eb = (n > 0) ? m_beg[n-1] : '0;
        ee = (n > 0) ? m_end[n-1] : '0;
        ec = (n > 0) ? m_cnt[n-1] : '0;
        total++;
        if (top_beg_o !== eb || top_end_o !== ee || top_cnt_o !== ec ||
            empty_o !== xe || full_o !== xf) begin
            bad++;
            $display("FAIL %s: got beg=%h end=%h cnt=%h empty=%b full=%b, expected beg=%h end=%h cnt=%h empty=%b full=%b",
                     tag, top_beg_o, top_end_o, top_cnt_o, empty_o, full_o,
                     eb, ee, ec, xe, xf);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, check a cycle later
    task automatic step(input logic p, input logic po, input logic d, input logic c,
                        input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] e,
                        input logic [CNT_W-1:0] k, input string tag);
        push = p; pop = po; dec = d; clr = c;
        beg_i = b; end_i = e; cnt_i = k;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 async reset held");
        compare("R10 zero fields while empty");
        arst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        step(0, 1, 0, 0, 16'h0000, 16'h0000, 16'd0, "R7 pop on empty");
        step(0, 0, 1, 0, 16'h0000, 16'h0000, 16'd0, "R7 dec on empty");
        step(1, 0, 0, 0, 16'h0100, 16'h0120, 16'd2, "R2 first push");
        step(1, 0, 0, 0, 16'h0200, 16'h0230, 16'd2, "R2 second push reaches full");
        step(1, 0, 0, 0, 16'h0300, 16'h0330, 16'd7, "R6 push while full ignored");
        step(0, 0, 1, 0, 16'h0000, 16'h0000, 16'd0, "R4 decrement 2 to 1");
        step(0, 0, 1, 0, 16'h0000, 16'h0000, 16'd0, "R4 decrement 1 to 0");
        step(0, 0, 1, 0, 16'h0000, 16'h0000, 16'd0, "R5 decrement at zero");
        step(1, 0, 1, 0, 16'h0400, 16'h0440, 16'd5, "R9 refused push also drops dec");
        step(0, 1, 0, 0, 16'h0000, 16'h0000, 16'd0, "R3 pop reveals lower entry");
        step(1, 0, 1, 0, 16'h0500, 16'h0550, 16'd4, "R9 push beats dec");
        step(0, 1, 1, 0, 16'h0000, 16'h0000, 16'd0, "R9 pop beats dec");
        step(1, 1, 0, 0, 16'h0600, 16'h0660, 16'd9, "R8 push and pop replace top");
        step(1, 1, 1, 1, 16'h0700, 16'h0770, 16'd1, "R1 clear overrides strobes");
        step(1, 1, 0, 0, 16'h0800, 16'h0880, 16'd3, "R8 push and pop on empty push");
        step(0, 0, 1, 0, 16'h0000, 16'h0000, 16'd0, "R4 decrement single entry");
        step(0, 1, 0, 0, 16'h0000, 16'h0000, 16'd0, "R10 zero after last pop");

        // Asynchronous reset in mid-run: effect without a clock edge
        step(1, 0, 0, 0, 16'h0900, 16'h0990, 16'd6, "R2 refill");
        step(1, 0, 0, 0, 16'h0a00, 16'h0aa0, 16'd6, "R2 refill to full");
        push = 0; pop = 0; dec = 0; clr = 0;
        #2 arst_n = 1'b0;
        #1 model_clear();
        compare("R1 async reset mid-run");
        @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        compare("R1 after mid-run release");

        // Mixed traffic with small counts so zero counts occur often
        for (int i = 0; i < 600; i++) begin
            int r;
            logic p;
            logic po;
            logic d;
            logic c;
            r  = $urandom_range(0, 99);
            p  = (r < 30) || (r >= 90);
            po = (r >= 30 && r < 50) || (r >= 85);
            d  = (r >= 50 && r < 85) || (r >= 95);
            c  = ($urandom_range(0, 63) == 0);
            step(p, po, d, c, 16'($urandom), 16'($urandom), 16'($urandom_range(0, 3)),
                 "R2 R3 R4 R5 R8 R9 mixed traffic");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule